// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This combinational unit sits beside a single-precision arithmetic datapath and decides what an operation returns when NaNs are involved. It looks at the two or three source operands, at a hint from the multiplier that the product is infinity times zero, and at an encoding mode bit. From these it reports whether a NaN result applies, which 32-bit NaN pattern to deliver, and whether the invalid-operation exception must be raised. When no NaN result applies, the caller uses its own arithmetic result.

The encoding mode bit changes several things at once. With the mode bit low (legacy encoding) a set fraction MSB marks a signaling NaN, operand payloads are never propagated and every NaN result collapses to the legacy default NaN. With the mode bit high (2008 encoding) a clear fraction MSB marks a signaling NaN, and the result is one of the operand NaNs, picked by a fixed priority and quieted by setting its fraction MSB.

Top module: `nan_result_select`

## Requirements
- R1: An operand is a NaN only when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero; an infinity (all-ones exponent, zero fraction) is never a NaN of either kind.
- R2: With `ieee2008` low a NaN whose fraction MSB (bit 22) is 1 is signaling and one with bit 22 clear is quiet; with `ieee2008` high the polarity is reversed.
- R3: With `ieee2008` low, every NaN result (`nan_valid` high) is 0x7FBFFFFF, whatever the operand payloads.
- R4: With `ieee2008` high, when `prod_inf_zero` is high and no NaN third operand takes part, the result is 0x7FC00000.
- R5: With `ieee2008` high and `fma_op` low, the result is taken from A if A is signaling, else B if B is signaling, else A if A is quiet, else B.
- R6: An operand returned in 2008 mode has bit 22 forced to 1, with the sign, exponent and other fraction bits unchanged.
- R7: With `ieee2008` high and `fma_op` high, the result is the first signaling NaN in the order C, A, B; if none is signaling, the first quiet NaN in the order C, A, B.
- R8: When `prod_inf_zero` is high, `nan_valid` and `invalid` are both high; with `fma_op` high, C a NaN and `ieee2008` high the result is the quieted C, and otherwise the result is the default NaN of the active mode.
- R9: `invalid` is high exactly when `prod_inf_zero` is high or a participating operand is a signaling NaN under the active encoding.
- R10: When no participating operand is a NaN and `prod_inf_zero` is low, `nan_valid` and `invalid` are low and `nan_result` is zero.
- R11: With `fma_op` low, operand C has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| op_c | input | 32 | Addend operand, used only when fma_op is high |
| fma_op | input | 1 | High for a three-operand fused multiply-add |
| prod_inf_zero | input | 1 | High when the product A×B is infinity times zero |
| ieee2008 | input | 1 | Encoding mode: 0 legacy, 1 IEEE 754-2008 |
| nan_valid | output | 1 | A NaN result applies to this operation |
| nan_result | output | 32 | The NaN pattern to return when nan_valid is high |
| invalid | output | 1 | Invalid-operation exception |

## Verification
The unit holds no state, so a fault in its classification or priority logic shows on the outputs in the same cycle the offending operands are applied. A wrong signaling-bit polarity flips `invalid` for every NaN operand and, in 2008 mode, moves the chosen operand; a wrong priority shows only when two or more operands are NaN of the same or differing kinds, which is why the sweep covers every mix of zero, normal, infinity and both NaN kinds on all three operands, in both modes, with and without the fused and infinity-times-zero inputs.

// File: rtl/nansel_pkg.sv
package nansel_pkg;

  // Per-operand classification result
  typedef struct packed {
    logic is_nan;
    logic is_sig;
    logic is_quiet;
  } nan_cls_t;

  // Which value drives the NaN result
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_A    = 3'd1,
    SRC_B    = 3'd2,
    SRC_C    = 3'd3,
    SRC_DFLT = 3'd4
  } nan_src_e;

  localparam int unsigned NUM_OPS = 3;
  localparam int unsigned IDX_A   = 0;
  localparam int unsigned IDX_B   = 1;
  localparam int unsigned IDX_C   = 2;

endpackage

// File: rtl/nansel_classify.sv
module nansel_classify
  import nansel_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  ieee2008,
  input  logic                  enable,
  output nan_cls_t              cls
);
  localparam int unsigned W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              frac_msb;
  logic              nan_raw;

  always_comb begin
    exp_f    = operand[W-2 -: EXP_W];
    frac_f   = operand[FRAC_W-1:0];
    frac_msb = frac_f[FRAC_W-1];
    // an all-ones exponent with zero fraction is infinity, not NaN
    nan_raw  = (&exp_f) && (|frac_f) && enable;
    cls.is_nan   = nan_raw;
    // legacy: msb set means signaling; 2008: msb clear means signaling
    cls.is_sig   = nan_raw && (ieee2008 ? ~frac_msb : frac_msb);
    cls.is_quiet = nan_raw && (ieee2008 ? frac_msb : ~frac_msb);
  end

endmodule

// File: rtl/nansel_order.sv
module nansel_order
  import nansel_pkg::*;
(
  input  nan_cls_t cls_a,
  input  nan_cls_t cls_b,
  input  nan_cls_t cls_c,
  input  logic     fma_op,
  input  logic     prod_inf_zero,
  input  logic     ieee2008,
  output nan_src_e src
);
  logic any_nan;

  always_comb begin
    any_nan = cls_a.is_nan | cls_b.is_nan | cls_c.is_nan;
    src     = SRC_NONE;
    if (prod_inf_zero) begin
      src = (ieee2008 && fma_op && cls_c.is_nan) ? SRC_C : SRC_DFLT;
    end else if (!any_nan) begin
      src = SRC_NONE;
    end else if (!ieee2008) begin
      src = SRC_DFLT;
    end else if (fma_op) begin
      if      (cls_c.is_sig)   src = SRC_C;
      else if (cls_a.is_sig)   src = SRC_A;
      else if (cls_b.is_sig)   src = SRC_B;
      else if (cls_c.is_quiet) src = SRC_C;
      else if (cls_a.is_quiet) src = SRC_A;
      else                     src = SRC_B;
    end else begin
      if      (cls_a.is_sig)   src = SRC_A;
      else if (cls_b.is_sig)   src = SRC_B;
      else if (cls_a.is_quiet) src = SRC_A;
      else                     src = SRC_B;
    end
  end

endmodule

// File: rtl/nan_result_select.sv
module nan_result_select
  import nansel_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [EXP_W+FRAC_W:0] op_c,
  input  logic                  fma_op,
  input  logic                  prod_inf_zero,
  input  logic                  ieee2008,
  output logic                  nan_valid,
  output logic [EXP_W+FRAC_W:0] nan_result,
  output logic                  invalid
);
  localparam int unsigned W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DN_2008 =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DN_LEGACY =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic     [W-1:0] ops [NUM_OPS];
  nan_cls_t         cls [NUM_OPS];
  nan_src_e         src;
  logic             any_sig;

  assign ops[IDX_A] = op_a;
  assign ops[IDX_B] = op_b;
  assign ops[IDX_C] = op_c;

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_cls
    nansel_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .operand (ops[gi]),
      .ieee2008(ieee2008),
      .enable  ((gi == IDX_C) ? fma_op : 1'b1),
      .cls     (cls[gi])
    );
  end

  nansel_order u_order (
    .cls_a        (cls[IDX_A]),
    .cls_b        (cls[IDX_B]),
    .cls_c        (cls[IDX_C]),
    .fma_op       (fma_op),
    .prod_inf_zero(prod_inf_zero),
    .ieee2008     (ieee2008),
    .src          (src)
  );

  always_comb begin
    any_sig   = cls[IDX_A].is_sig | cls[IDX_B].is_sig | cls[IDX_C].is_sig;
    nan_valid = (src != SRC_NONE);
    invalid   = prod_inf_zero | any_sig;
    unique case (src)
      SRC_A:    nan_result = op_a | QUIET_MASK;
      SRC_B:    nan_result = op_b | QUIET_MASK;
      SRC_C:    nan_result = op_c | QUIET_MASK;
      SRC_DFLT: nan_result = ieee2008 ? DN_2008 : DN_LEGACY;
      default:  nan_result = '0;
    endcase
  end

endmodule

// File: rtl/nansel_checker.sv
module nansel_checker #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  fma_op,
  input logic                  prod_inf_zero,
  input logic                  ieee2008,
  input logic                  nan_valid,
  input logic [EXP_W+FRAC_W:0] nan_result,
  input logic                  invalid
);
  localparam int unsigned W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QMASK = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] LEG_DN =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  always_comb begin
    // R10: no NaN result means zero result and no exception from operands
    assert_idle_zero_R10: assert (nan_valid || (nan_result == '0))
      else $error("R10 result not zero while nan_valid low");
    // R8: infinity times zero always yields a flagged NaN result
    assert_infzero_flags_R8: assert (!prod_inf_zero || (nan_valid && invalid))
      else $error("R8 inf*zero without valid and invalid");
    // R3: legacy mode never propagates a payload
    assert_legacy_default_R3: assert (!(nan_valid && !ieee2008) || (nan_result == LEG_DN))
      else $error("R3 legacy result not default NaN");
    // R6: every 2008 result is quiet
    assert_quiet_out_R6: assert (!(nan_valid && ieee2008) || nan_result[FRAC_W-1])
      else $error("R6 2008 result not quiet");
    // R1: every result is a NaN
    assert_result_nan_R1: assert (!nan_valid ||
        ((&nan_result[W-2 -: EXP_W]) && (|nan_result[FRAC_W-1:0])))
      else $error("R1 result is not a NaN");
    // R5: two-operand 2008 result is one of the quieted sources
    assert_two_op_source_R5: assert (!(nan_valid && ieee2008 && !fma_op && !prod_inf_zero) ||
        (nan_result == (op_a | QMASK)) || (nan_result == (op_b | QMASK)))
      else $error("R5 result not taken from A or B");
  end

endmodule

bind nan_result_select nansel_checker #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_nansel_checker (
  .op_a         (op_a),
  .op_b         (op_b),
  .fma_op       (fma_op),
  .prod_inf_zero(prod_inf_zero),
  .ieee2008     (ieee2008),
  .nan_valid    (nan_valid),
  .nan_result   (nan_result),
  .invalid      (invalid)
);

// File: tb/nan_result_select_test.sv
module nan_result_select_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b, op_c;
  logic        fma_op, prod_inf_zero, ieee2008;
  logic        nan_valid, invalid;
  logic [31:0] nan_result;
  int          n_checks;
  int          n_fail;
  bit          done;

  nan_result_select uut (
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .fma_op(fma_op), .prod_inf_zero(prod_inf_zero), .ieee2008(ieee2008),
    .nan_valid(nan_valid), .nan_result(nan_result), .invalid(invalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] pool [8];
  initial begin
    pool[0] = 32'h0000_0000;  // zero
    pool[1] = 32'h3F80_0000;  // 1.0
    pool[2] = 32'h7F80_0000;  // +inf
    pool[3] = 32'hFF80_0000;  // -inf
    pool[4] = 32'h7FC0_1234;  // NaN, bit22 set
    pool[5] = 32'hFFA0_0005;  // NaN, bit22 clear
    pool[6] = 32'h7F80_0001;  // NaN, bit22 clear, tiny payload
    pool[7] = 32'hFFC0_0000;  // NaN, bit22 set, negative
  end

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction
  function automatic bit is_snan(input logic [31:0] x, input bit m);
    return is_nan(x) && (m ? (x[22] == 1'b0) : (x[22] == 1'b1));
  endfunction
  function automatic bit is_qnan(input logic [31:0] x, input bit m);
    return is_nan(x) && !is_snan(x, m);
  endfunction

  // reference: {valid, invalid, result}
  function automatic logic [33:0] model(input logic [31:0] a, b, c,
                                        input bit f, iz, m);
    logic [31:0] dn;
    logic [31:0] r;
    bit cn, v, inv;
    dn  = m ? 32'h7FC0_0000 : 32'h7FBF_FFFF;
    cn  = f && is_nan(c);
    inv = iz || is_snan(a, m) || is_snan(b, m) || (f && is_snan(c, m));
    v   = iz || is_nan(a) || is_nan(b) || cn;
    r   = 32'h0;
    if (iz) r = (m && cn) ? (c | 32'h0040_0000) : dn;
    else if (v && !m) r = dn;
    else if (v && f) begin
      if      (is_snan(c, m)) r = c;
      else if (is_snan(a, m)) r = a;
      else if (is_snan(b, m)) r = b;
      else if (is_qnan(c, m)) r = c;
      else if (is_qnan(a, m)) r = a;
      else                    r = b;
      r = r | 32'h0040_0000;
    end else if (v) begin
      if      (is_snan(a, m)) r = a;
      else if (is_snan(b, m)) r = b;
      else if (is_qnan(a, m)) r = a;
      else                    r = b;
      r = r | 32'h0040_0000;
    end
    return {v, inv, r};
  endfunction

  task automatic apply(input logic [31:0] a, b, c, input bit f, iz, m);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c;
    fma_op = f; prod_inf_zero = iz; ieee2008 = m;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [33:0] exp_v);
    n_checks++;
    if ({nan_valid, invalid, nan_result} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b inv=%0b res=%08h, expected valid=%0b inv=%0b res=%08h",
               req, nan_valid, invalid, nan_result, exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    op_a = '0; op_b = '0; op_c = '0;
    fma_op = 1'b0; prod_inf_zero = 1'b0; ieee2008 = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: quiet inputs give no NaN result (R10)
    apply(32'h0, 32'h0, 32'h0, 0, 0, 0);
    check("R10 reset", {2'b00, 32'h0});

    // R1: infinities are not NaNs in either mode
    apply(32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0000, 1, 0, 0);
    check("R1 inf legacy", {2'b00, 32'h0});
    apply(32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0000, 1, 0, 1);
    check("R1 inf 2008", {2'b00, 32'h0});

    // R2: polarity of the signaling bit
    apply(32'h7FC0_0000, 32'h3F80_0000, 32'h0, 0, 0, 0);
    check("R2 legacy bit22 set signals", {2'b11, 32'h7FBF_FFFF});
    apply(32'h7FC0_0000, 32'h3F80_0000, 32'h0, 0, 0, 1);
    check("R2 2008 bit22 set quiet", {2'b10, 32'h7FC0_0000});

    // R4: 2008 default NaN from inf*zero
    apply(32'h7F80_0000, 32'h0, 32'h3F80_0000, 1, 1, 1);
    check("R4 2008 default", {2'b11, 32'h7FC0_0000});

    // R6: silencing keeps sign and payload
    apply(32'hFFA0_0005, 32'h3F80_0000, 32'h0, 0, 0, 1);
    check("R6 silence", {2'b11, 32'hFFE0_0005});

    // R9: signaling C in fused op raises invalid
    apply(32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0001, 1, 0, 1);
    check("R9 sig C", {2'b11, 32'h7FC0_0001});

    // R11: C ignored when not fused
    apply(32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0001, 0, 0, 1);
    check("R11 C ignored 2008", {2'b00, 32'h0});
    apply(32'h3F80_0000, 32'h3F80_0000, 32'h7FC0_0001, 0, 0, 0);
    check("R11 C ignored legacy", {2'b00, 32'h0});

    // R7: quiet C beats signaling-free A in fused 2008
    apply(32'hFFC0_0000, 32'h0, 32'h7FC0_1234, 1, 0, 1);
    check("R7 quiet C first", {2'b10, 32'h7FC0_1234});

    // R8: inf*zero with NaN C in 2008 returns quieted C
    apply(32'h0, 32'h7F80_0000, 32'hFFA0_0005, 1, 1, 1);
    check("R8 inf0 C 2008", {2'b11, 32'hFFE0_0005});

    // sweep every pool combination in every control setting
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          for (int ic = 0; ic < 8; ic++) begin
            logic [33:0] e;
            string tag;
            bit f, iz, m;
            f  = ctl[0]; iz = ctl[1]; m = ctl[2];
            e  = model(pool[ia], pool[ib], pool[ic], f, iz, m);
            if (iz)                tag = "R8 sweep";
            else if (!e[33])       tag = "R10 sweep";
            else if (!m)           tag = "R3 sweep";
            else if (f)            tag = "R7 sweep";
            else                   tag = "R5 sweep";
            apply(pool[ia], pool[ib], pool[ic], f, iz, m);
            check(tag, e);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule